// File: doc/BRIEF.md
# Warp Engine Command Token Parser

This block sits at the front of an image warping and scaling engine. It takes a stream of 32-bit command tokens through a valid/ready input. Each token is one of two kinds. A configure token carries a register index and a value, and the block writes that value into a small local register file. A data token is one word of a job descriptor. The block collects data tokens one by one until a descriptor is complete.

How many data words make up a descriptor, and what each word means, depends on a processing-mode register:

- **Scaling mode** (the reset default) needs three words:
  - one packed word holding the horizontal ratio, the horizontal phase offset and the vertical ratio;
  - a source address;
  - a destination address.
- **Tetragon mode** needs ten words:
  - eight corner coordinates;
  - a source address;
  - a destination address.

When the last word of a descriptor arrives, the block presents the whole job as one parallel bundle on a valid/ready output. It does not accept further tokens until that bundle has been taken.

A read port lets the downstream engine read any configuration register. A sticky error flag records writes to register indices that do not exist. A status pair reports the position inside the current data sequence and whether the parser is idle.

Top module: `warp_cmd_parser`

## Requirements
- R1: A token with bit 31 = 1 is a configure token. Its bits 23:0 are written into general register `in_data[29:25]`, for indices 0 to 15. Bit 24 of the value field is discarded. The new value is visible on `rd_data` when `rd_idx` selects that index, from the cycle after acceptance.
- R2: A token with bit 31 = 0 is a data token. It never changes any register and never raises the error flag, whatever its bits 29:25 hold.
- R3: The mode register is at index 27. Only value bit 0 is stored: 1 selects tetragon mode and 0 selects scaling mode. It resets to 0, and it reads back as `{23'b0, mode}`.
- R4: In scaling mode, three data tokens w0, w1, w2 produce a descriptor with these fields:
  - `desc_ratio_x` = w0[9:0], `desc_phase_x` = w0[15:10], `desc_ratio_y` = w0[25:16];
  - `desc_src` = w1[23:0], `desc_dst` = w2[23:0];
  - `desc_corners` = 0 and `desc_tetra` = 0.
  Bits 29:26 of w0 play no part.
- R5: In tetragon mode, ten data tokens d0 to d9 produce a descriptor with these fields:
  - corner k, taken from d_k[23:0], at `desc_corners[24k+23:24k]`, in the order P0X, P0Y, P1X, P1Y, P2X, P2Y, P3X, P3Y;
  - `desc_src` = d8[23:0], `desc_dst` = d9[23:0];
  - the ratio and phase fields zero, and `desc_tetra` = 1.
- R6: `desc_run` equals bit 30 of the first data token of the sequence. Bit 30 of later tokens is ignored.
- R7: A configure token accepted while a sequence is partly collected is still written, and it leaves `stat_count` unchanged.
- R8: The mode in force when the first data token of a sequence is accepted sets that sequence's length and layout. A mode write during the sequence takes effect from the next sequence.
- R9: While `desc_valid` is high and `desc_ready` is low, three things hold:
  - `in_ready` is low;
  - no token is consumed;
  - every descriptor field stays unchanged.
  After the descriptor is accepted, `in_ready` is high again in the following cycle.
- R10: A configure token to an index that is neither 0 to 15 nor 27 changes no register and sets the sticky `err_flag`. A one-cycle `err_clr` clears the flag. If a bad write and `err_clr` happen in the same cycle, the flag stays set.
- R11: `stat_count` is the number of data tokens accepted in the current sequence. It returns to 0 when the sequence completes. `stat_idle` is high exactly when `stat_count` is 0 and no descriptor is pending.
- R12: After reset, the outputs are:
  - `in_ready` = 1, `desc_valid` = 0;
  - `stat_count` = 0, `stat_idle` = 1;
  - `err_flag` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Parser can take a token |
| in_data | input | 32 | Command token |
| rd_idx | input | 5 | Configuration read index |
| rd_data | output | 24 | Value of the selected register, 0 if not implemented |
| err_clr | input | 1 | Clear pulse for the error flag |
| err_flag | output | 1 | Sticky bad-index error |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Descriptor taken by the consumer |
| desc_tetra | output | 1 | Descriptor layout: 1 = tetragon, 0 = scaling |
| desc_run | output | 1 | Run-type flag of the job |
| desc_ratio_x | output | 10 | Horizontal ratio (scaling) |
| desc_phase_x | output | 6 | Horizontal phase offset (scaling) |
| desc_ratio_y | output | 10 | Vertical ratio (scaling) |
| desc_corners | output | 192 | Eight 24-bit corner coordinates (tetragon) |
| desc_src | output | 24 | Source address |
| desc_dst | output | 24 | Destination address |
| stat_count | output | 4 | Data tokens collected in the current sequence |
| stat_idle | output | 1 | No partial sequence and no pending descriptor |

## Verification
The hardest case to reach is a mode change that lands inside a sequence that has already started. The bench has to interleave a configure token between data tokens, so that the latched mode and the register disagree. It does this in both directions:
- It starts a scaling sequence, switches to tetragon after the first word, and expects completion after three words.
- It starts a tetragon sequence, switches back to scaling after three words, and expects completion only after ten words.

A back-pressure stall is held for several cycles with a token still offered. This shows that nothing is consumed and that the bundle does not move.

// File: rtl/warp_cmd_pkg.sv
package warp_cmd_pkg;
    // Token field positions (decoded by the parser and by the producer)
    localparam int TOK_W    = 32;
    localparam int CMD_BIT  = 31;
    localparam int RUN_BIT  = 30;
    localparam int IDX_LSB  = 25;
    localparam int IDX_W    = 5;
    localparam int VAL_W    = 24;
    localparam int PACK_W   = 26;
    // Packed scaling word layout
    localparam int RX_LSB   = 0;
    localparam int RX_W     = 10;
    localparam int PH_LSB   = 10;
    localparam int PH_W     = 6;
    localparam int RY_LSB   = 16;
    localparam int RY_W     = 10;
    // Register map defaults
    localparam int GEN_REGS = 16;
    localparam int MODE_REG = 27;
    localparam int CORNERS  = 8;

    typedef logic [IDX_W-1:0] reg_idx_t;
endpackage

// File: rtl/wcp_regfile.sv
module wcp_regfile #(
    parameter int NUM_GEN  = warp_cmd_pkg::GEN_REGS,
    parameter int MODE_IDX = warp_cmd_pkg::MODE_REG,
    parameter int IDX_W    = warp_cmd_pkg::IDX_W,
    parameter int VAL_W    = warp_cmd_pkg::VAL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VAL_W-1:0] wr_val,
    input  logic             err_clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VAL_W-1:0] rd_data,
    output logic             mode_tetra,
    output logic             err_flag
);
    localparam int GEN_AW = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;
    localparam logic [IDX_W:0]   GEN_LIM  = (IDX_W+1)'(NUM_GEN);
    localparam logic [IDX_W-1:0] MODE_SEL = IDX_W'(MODE_IDX);

    typedef struct packed {
        logic [NUM_GEN-1:0][VAL_W-1:0] gen;
        logic                          tetra;
        logic                          err;
    } rf_t;

    rf_t rf_d, rf_q;
    logic wr_hit_gen, wr_hit_mode, wr_bad;

    always_comb begin
        wr_hit_gen  = ({1'b0, wr_idx} < GEN_LIM);
        wr_hit_mode = (wr_idx == MODE_SEL) && !wr_hit_gen;
        wr_bad      = !wr_hit_gen && !wr_hit_mode;
        rf_d        = rf_q;
        if (wr_en && wr_hit_gen)  rf_d.gen[wr_idx[GEN_AW-1:0]] = wr_val;
        if (wr_en && wr_hit_mode) rf_d.tetra = wr_val[0];
        if (err_clr)              rf_d.err = 1'b0;
        if (wr_en && wr_bad)      rf_d.err = 1'b1;   // set wins over clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        if ({1'b0, rd_idx} < GEN_LIM)
            rd_data = rf_q.gen[rd_idx[GEN_AW-1:0]];
        else if (rd_idx == MODE_SEL)
            rd_data = {{(VAL_W-1){1'b0}}, rf_q.tetra};
        else
            rd_data = '0;
    end

    assign mode_tetra = rf_q.tetra;
    assign err_flag   = rf_q.err;

    assert_bad_write_sets_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bad) |=> err_flag);

    assert_mode_only_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == MODE_SEL) |=> $stable(mode_tetra));

    assert_err_needs_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_flag && !(wr_en && wr_bad)) |=> !err_flag);
endmodule

// File: rtl/wcp_collector.sv
module wcp_collector #(
    parameter int VAL_W   = warp_cmd_pkg::VAL_W,
    parameter int PACK_W  = warp_cmd_pkg::PACK_W,
    parameter int CORNERS = warp_cmd_pkg::CORNERS,
    parameter int CNT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     data_we,
    input  logic [PACK_W-1:0]        payload,
    input  logic                     run_bit,
    input  logic                     mode_tetra,
    input  logic                     desc_ready,
    output logic                     desc_valid,
    output logic                     desc_tetra,
    output logic                     desc_run,
    output logic [warp_cmd_pkg::RX_W-1:0] desc_ratio_x,
    output logic [warp_cmd_pkg::PH_W-1:0] desc_phase_x,
    output logic [warp_cmd_pkg::RY_W-1:0] desc_ratio_y,
    output logic [CORNERS*VAL_W-1:0] desc_corners,
    output logic [VAL_W-1:0]         desc_src,
    output logic [VAL_W-1:0]         desc_dst,
    output logic [CNT_W-1:0]         stat_count,
    output logic                     stat_idle
);
    import warp_cmd_pkg::*;

    localparam int SCALE_LEN = 3;
    localparam int TETRA_LEN = CORNERS + 2;
    localparam int MAX_LEN   = TETRA_LEN;
    localparam logic [CNT_W-1:0] SCALE_LAST = CNT_W'(SCALE_LEN - 1);
    localparam logic [CNT_W-1:0] TETRA_LAST = CNT_W'(TETRA_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0]               count;
        logic                           tetra;
        logic                           run;
        logic                           valid;
        logic [MAX_LEN-1:0][PACK_W-1:0] slots;
    } col_t;

    col_t col_d, col_q;
    logic cur_tetra;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        col_d     = col_q;
        // the first word of a sequence latches the mode; later words follow it
        cur_tetra = (col_q.count == '0) ? mode_tetra : col_q.tetra;
        last_idx  = cur_tetra ? TETRA_LAST : SCALE_LAST;
        if (col_q.valid && desc_ready) col_d.valid = 1'b0;
        if (data_we) begin
            if (col_q.count == '0) begin
                col_d.tetra = mode_tetra;
                col_d.run   = run_bit;
            end
            col_d.slots[col_q.count] = payload;
            if (col_q.count == last_idx) begin
                col_d.count = '0;
                col_d.valid = 1'b1;
            end else begin
                col_d.count = col_q.count + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) col_q <= '0;
        else        col_q <= col_d;
    end

    // Output layout selected by the latched mode
    for (genvar k = 0; k < CORNERS; k++) begin : g_corner
        assign desc_corners[k*VAL_W +: VAL_W] = col_q.tetra ? col_q.slots[k][VAL_W-1:0] : '0;
    end

    assign desc_ratio_x = col_q.tetra ? '0 : col_q.slots[0][RX_LSB +: RX_W];
    assign desc_phase_x = col_q.tetra ? '0 : col_q.slots[0][PH_LSB +: PH_W];
    assign desc_ratio_y = col_q.tetra ? '0 : col_q.slots[0][RY_LSB +: RY_W];
    assign desc_src     = col_q.tetra ? col_q.slots[CORNERS][VAL_W-1:0]   : col_q.slots[1][VAL_W-1:0];
    assign desc_dst     = col_q.tetra ? col_q.slots[CORNERS+1][VAL_W-1:0] : col_q.slots[2][VAL_W-1:0];
    assign desc_valid   = col_q.valid;
    assign desc_tetra   = col_q.tetra;
    assign desc_run     = col_q.run;
    assign stat_count   = col_q.count;
    assign stat_idle    = (col_q.count == '0) && !col_q.valid;

    logic unused_slot_bits;
    always_comb begin
        unused_slot_bits = 1'b0;
        for (int s = 1; s < MAX_LEN; s++)
            unused_slot_bits = unused_slot_bits ^ (^col_q.slots[s][PACK_W-1:VAL_W]);
    end

    assert_count_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_count < CNT_W'(MAX_LEN));

    assert_no_take_while_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> !data_we);

    assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_src) && $stable(desc_dst)
                                         && $stable(desc_run) && $stable(desc_corners)));

    assert_partial_not_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_count != '0) |-> !desc_valid);
endmodule

// File: rtl/warp_cmd_parser.sv
module warp_cmd_parser #(
    parameter int NUM_GEN  = warp_cmd_pkg::GEN_REGS,
    parameter int MODE_IDX = warp_cmd_pkg::MODE_REG,
    parameter int CORNERS  = warp_cmd_pkg::CORNERS,
    parameter int VAL_W    = warp_cmd_pkg::VAL_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [warp_cmd_pkg::TOK_W-1:0]    in_data,
    input  logic [warp_cmd_pkg::IDX_W-1:0]    rd_idx,
    output logic [VAL_W-1:0]                  rd_data,
    input  logic                              err_clr,
    output logic                              err_flag,
    output logic                              desc_valid,
    input  logic                              desc_ready,
    output logic                              desc_tetra,
    output logic                              desc_run,
    output logic [warp_cmd_pkg::RX_W-1:0]     desc_ratio_x,
    output logic [warp_cmd_pkg::PH_W-1:0]     desc_phase_x,
    output logic [warp_cmd_pkg::RY_W-1:0]     desc_ratio_y,
    output logic [CORNERS*VAL_W-1:0]          desc_corners,
    output logic [VAL_W-1:0]                  desc_src,
    output logic [VAL_W-1:0]                  desc_dst,
    output logic [$clog2(CORNERS+3)-1:0]      stat_count,
    output logic                              stat_idle
);
    import warp_cmd_pkg::*;

    localparam int CNT_W = $clog2(CORNERS + 3);

    logic     fire, cfg_we, data_we, mode_tetra;
    reg_idx_t tok_idx;

    assign in_ready = !desc_valid;
    assign fire     = in_valid && in_ready;
    assign cfg_we   = fire &&  in_data[CMD_BIT];
    assign data_we  = fire && !in_data[CMD_BIT];
    assign tok_idx  = in_data[IDX_LSB +: IDX_W];

    logic unused_tok_bits;
    assign unused_tok_bits = in_data[VAL_W];

    wcp_regfile #(
        .NUM_GEN (NUM_GEN),
        .MODE_IDX(MODE_IDX),
        .IDX_W   (IDX_W),
        .VAL_W   (VAL_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (tok_idx),
        .wr_val    (in_data[VAL_W-1:0]),
        .err_clr   (err_clr),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .mode_tetra(mode_tetra),
        .err_flag  (err_flag)
    );

    wcp_collector #(
        .VAL_W  (VAL_W),
        .PACK_W (PACK_W),
        .CORNERS(CORNERS),
        .CNT_W  (CNT_W)
    ) u_col (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_we     (data_we),
        .payload     (in_data[PACK_W-1:0]),
        .run_bit     (in_data[RUN_BIT]),
        .mode_tetra  (mode_tetra),
        .desc_ready  (desc_ready),
        .desc_valid  (desc_valid),
        .desc_tetra  (desc_tetra),
        .desc_run    (desc_run),
        .desc_ratio_x(desc_ratio_x),
        .desc_phase_x(desc_phase_x),
        .desc_ratio_y(desc_ratio_y),
        .desc_corners(desc_corners),
        .desc_src    (desc_src),
        .desc_dst    (desc_dst),
        .stat_count  (stat_count),
        .stat_idle   (stat_idle)
    );

    assert_cfg_keeps_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> $stable(stat_count));

    assert_data_keeps_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !err_flag && !(cfg_we)) |=> !err_flag);
endmodule

// File: tb/sim_warp_cmd_parser.sv
module sim_warp_cmd_parser;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 24;
    localparam int NC = 8;

    logic clk, rst_n, in_valid, in_ready, err_clr, err_flag;
    logic desc_valid, desc_ready, desc_tetra, desc_run, stat_idle;
    logic [31:0] in_data;
    logic [4:0]  rd_idx;
    logic [VW-1:0] rd_data, desc_src, desc_dst;
    logic [9:0]  desc_ratio_x, desc_ratio_y;
    logic [5:0]  desc_phase_x;
    logic [NC*VW-1:0] desc_corners;
    logic [3:0]  stat_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    warp_cmd_parser u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .err_clr(err_clr), .err_flag(err_flag),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_tetra(desc_tetra),
        .desc_run(desc_run), .desc_ratio_x(desc_ratio_x), .desc_phase_x(desc_phase_x),
        .desc_ratio_y(desc_ratio_y), .desc_corners(desc_corners), .desc_src(desc_src),
        .desc_dst(desc_dst), .stat_count(stat_count), .stat_idle(stat_idle)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL R12 watchdog: got %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [31:0] w0, w1, w2;
        logic        run;
        logic [9:0]  rx;
        logic [5:0]  ph;
        logic [9:0]  ry;
        logic [23:0] src, dst;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h0015_1C05, 32'h0012_3456, 32'h00AB_CDEF, 1'b0, 10'h005, 6'h07, 10'h015, 24'h123456, 24'hABCDEF},
        '{32'h7FFF_FFFF, 32'h01FF_FFFF, 32'h0000_0000, 1'b1, 10'h3FF, 6'h3F, 10'h3FF, 24'hFFFFFF, 24'h000000},
        '{32'h3C00_0000, 32'h0000_0001, 32'h3E00_0001, 1'b0, 10'h000, 6'h00, 10'h000, 24'h000001, 24'h000001},
        '{32'h0200_0400, 32'h0080_0000, 32'h4000_0010, 1'b0, 10'h000, 6'h01, 10'h200, 24'h800000, 24'h000010}
    };

    task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic send(input logic [31:0] t);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = t;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic cfg(input logic [4:0] idx, input logic [24:0] val);
        send({1'b1, 1'b0, idx, val});
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic accept();
        @(negedge clk);
        desc_ready = 1'b1;
        @(posedge clk);
        #1 desc_ready = 1'b0;
    endtask

    task automatic read_reg(input logic [4:0] i, output logic [23:0] v);
        rd_idx = i;
        #1 v = rd_data;
    endtask

    function automatic logic [23:0] tval(input int i);
        logic [31:0] p;
        p = 32'h0001_0101 * (i + 1);
        return p[23:0];
    endfunction

    logic [23:0] rv;
    logic [23:0] held_src;

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; desc_ready = 1'b0; err_clr = 1'b0; rd_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        settle();
        // R12 reset state
        check("R12", "in_ready", in_ready, 1);
        check("R12", "desc_valid", desc_valid, 0);
        check("R12", "stat_count", stat_count, 0);
        check("R12", "stat_idle", stat_idle, 1);
        check("R12", "err_flag", err_flag, 0);
        read_reg(5'd27, rv); check("R3", "mode after reset", rv, 0);

        // R1 configure writes and readback
        cfg(5'd5, 25'h0A5A5A5); settle();
        read_reg(5'd5, rv); check("R1", "reg5", rv, 24'hA5A5A5);
        cfg(5'd15, 25'h1FFFFFF); settle();
        read_reg(5'd15, rv); check("R1", "reg15 bit24 dropped", rv, 24'hFFFFFF);
        cfg(5'd0, 25'h0000123); settle();
        read_reg(5'd0, rv); check("R1", "reg0", rv, 24'h000123);
        check("R7", "count after cfg", stat_count, 0);

        // R4 / R6 / R11 scaling vectors
        for (int k = 0; k < 4; k++) begin
            send(VECS[k].w0); settle();
            check("R11", "count after w0", stat_count, 1);
            check("R11", "idle mid sequence", stat_idle, 0);
            send(VECS[k].w1); settle();
            check("R11", "count after w1", stat_count, 2);
            send(VECS[k].w2); settle();
            check("R4", "desc_valid", desc_valid, 1);
            check("R11", "count wrapped", stat_count, 0);
            check("R11", "idle while pending", stat_idle, 0);
            check("R9", "in_ready while pending", in_ready, 0);
            check("R4", "tetra flag", desc_tetra, 0);
            check("R6", "run flag", desc_run, VECS[k].run);
            check("R4", "ratio_x", desc_ratio_x, VECS[k].rx);
            check("R4", "phase_x", desc_phase_x, VECS[k].ph);
            check("R4", "ratio_y", desc_ratio_y, VECS[k].ry);
            check("R4", "src", desc_src, VECS[k].src);
            check("R4", "dst", desc_dst, VECS[k].dst);
            check("R4", "corners zero", (desc_corners == '0), 1);
            accept(); settle();
            check("R9", "valid after accept", desc_valid, 0);
            check("R9", "ready after accept", in_ready, 1);
            check("R11", "idle after accept", stat_idle, 1);
        end
        check("R2", "no error from data tokens", err_flag, 0);

        // R2 data token carrying an index field of 5 must not write
        send(32'h0A12_3456); settle();
        read_reg(5'd5, rv); check("R2", "reg5 untouched", rv, 24'hA5A5A5);
        check("R2", "count advanced", stat_count, 1);
        send(32'h0); send(32'h0); settle();
        check("R2", "sequence done", desc_valid, 1);
        accept();

        // R7 configure inside a sequence
        send(VECS[0].w0);
        cfg(5'd3, 25'h0000777); settle();
        check("R7", "count kept", stat_count, 1);
        read_reg(5'd3, rv); check("R7", "reg3 written", rv, 24'h000777);
        send(VECS[0].w1); send(VECS[0].w2); settle();
        check("R7", "desc_valid", desc_valid, 1);
        check("R7", "src", desc_src, VECS[0].src);
        check("R7", "dst", desc_dst, VECS[0].dst);
        accept();

        // R3 / R5 tetragon mode
        cfg(5'd27, 25'h0000001); settle();
        read_reg(5'd27, rv); check("R3", "mode readback", rv, 1);
        for (int i = 0; i < 10; i++) begin
            send({1'b0, (i == 0), 6'b0, tval(i)});
            if (i == 8) begin
                settle();
                check("R5", "count after nine", stat_count, 9);
                check("R5", "not yet valid", desc_valid, 0);
            end
        end
        settle();
        check("R5", "desc_valid", desc_valid, 1);
        check("R5", "tetra flag", desc_tetra, 1);
        check("R6", "run from first word", desc_run, 1);
        for (int c = 0; c < NC; c++)
            check("R5", $sformatf("corner %0d", c), desc_corners[c*VW +: VW], tval(c));
        check("R5", "src", desc_src, tval(8));
        check("R5", "dst", desc_dst, tval(9));
        check("R5", "ratio_x zero", desc_ratio_x, 0);
        check("R5", "phase zero", desc_phase_x, 0);
        check("R5", "ratio_y zero", desc_ratio_y, 0);
        accept();

        // R9 stall with a token offered
        cfg(5'd27, 25'h0);
        send(VECS[1].w0); send(VECS[1].w1); send(VECS[1].w2); settle();
        held_src = desc_src;
        in_valid = 1'b1; in_data = 32'h0000_0099;
        for (int s = 0; s < 3; s++) begin
            settle();
            check("R9", "ready low in stall", in_ready, 0);
            check("R9", "no token taken", stat_count, 0);
            check("R9", "src stable", desc_src, held_src);
            check("R9", "valid held", desc_valid, 1);
        end
        in_valid = 1'b0;
        accept(); settle();
        check("R9", "ready back", in_ready, 1);
        check("R9", "stalled token not taken", stat_count, 0);

        // R8 mode change inside a scaling sequence
        send(VECS[0].w0);
        cfg(5'd27, 25'h0000001);
        send(VECS[0].w1); send(VECS[0].w2); settle();
        check("R8", "scaling kept three words", desc_valid, 1);
        check("R8", "layout scaling", desc_tetra, 0);
        check("R8", "src", desc_src, VECS[0].src);
        accept();
        // R8 mode change inside a tetragon sequence
        for (int i = 0; i < 3; i++) send({8'h00, tval(i)});
        cfg(5'd27, 25'h0);
        settle();
        check("R8", "count after three", stat_count, 3);
        for (int i = 3; i < 10; i++) begin
            send({8'h00, tval(i)});
            if (i == 3) begin
                settle();
                check("R8", "not done at four", desc_valid, 0);
            end
        end
        settle();
        check("R8", "tetra kept ten words", desc_valid, 1);
        check("R8", "layout tetra", desc_tetra, 1);
        check("R8", "dst", desc_dst, tval(9));
        accept();

        // R10 unimplemented index
        cfg(5'd20, 25'h0000055); settle();
        check("R10", "err set", err_flag, 1);
        read_reg(5'd20, rv); check("R10", "idx20 reads zero", rv, 0);
        read_reg(5'd5, rv);  check("R10", "reg5 untouched", rv, 24'hA5A5A5);
        read_reg(5'd27, rv); check("R10", "mode untouched", rv, 0);
        cfg(5'd1, 25'h0000001); settle();
        check("R10", "err sticky", err_flag, 1);
        @(negedge clk) err_clr = 1'b1;
        @(posedge clk) #1 err_clr = 1'b0;
        settle();
        check("R10", "err cleared", err_flag, 0);
        @(negedge clk);
        err_clr = 1'b1; in_valid = 1'b1; in_data = {1'b1, 1'b0, 5'd28, 25'h1};
        @(posedge clk) #1;
        err_clr = 1'b0; in_valid = 1'b0;
        settle();
        check("R10", "set wins over clear", err_flag, 1);
        read_reg(5'd28, rv); check("R10", "idx28 reads zero", rv, 0);
        read_reg(5'd27, rv); check("R10", "mode unchanged by idx28", rv, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule